// File: doc/BRIEF.md
# Receive Descriptor Status Writeback

This block follows the receive descriptors that one incoming frame occupies and, once the frame has fully arrived, stores the frame's final status word into host memory. A descriptor-consumed event with the descriptor's address is given for each descriptor the frame fills. The frame-complete strobe carries the received byte count and an error code. The block then issues one or two word-write requests on a simple request/grant memory interface and signals completion with a one-cycle done pulse.

A frame that spans several descriptors gets the same status word in its first and in its last descriptor. Software that is working through the last descriptor therefore never has to go back to the first one. Descriptors in between are left untouched. A frame that occupies a single descriptor gets exactly one write. While writes are outstanding the block ignores every new descriptor event and frame strobe until the done pulse.

States: `S_IDLE` (no descriptor yet), `S_COLLECT` (at least one descriptor recorded), `S_WR_FIRST` (write to the first descriptor), `S_WR_LAST` (write to the last or only descriptor), `S_DONE` (done pulse). Transitions:
- `S_IDLE`→`S_COLLECT` on a descriptor event.
- `S_IDLE`→`S_WR_LAST` on a descriptor event together with the frame strobe.
- `S_COLLECT`→`S_WR_FIRST` on the frame strobe when two or more descriptors are recorded.
- `S_COLLECT`→`S_WR_LAST` on the frame strobe when one descriptor is recorded.
- `S_WR_FIRST`→`S_WR_LAST` on grant.
- `S_WR_LAST`→`S_DONE` on grant.
- `S_DONE`→`S_IDLE` unconditionally.

Top module: `rx_status_wb`

## Requirements
- R1: After reset, and until a frame strobe follows at least one descriptor event, `wr_req` and `done` stay low.
- R2: For a frame of two or more descriptors, exactly two writes are issued with identical data: first to the first descriptor's address, then to the last descriptor's address.
- R3: For a frame of one descriptor, exactly one write is issued, to that descriptor's address.
- R4: The status word has bit 31 = 0 (ownership returned to software), bit 30 = 1 (frame complete), bits 29:27 = 0, bits 26:16 = byte count, bits 15:10 = 0, bit 9 = 1 (first-descriptor flag), bit 8 = 1 (last-descriptor flag), bits 7:0 = error code.
- R5: Descriptors between the first and the last receive no write.
- R6: While `wr_req` is high and not granted, `wr_req`, `wr_addr` and `wr_data` hold their values.
- R7: `done` is high for exactly one cycle, the cycle after the final write is granted.
- R8: Descriptor events and frame strobes that arrive from the frame strobe until `done` have no effect on the writes in progress or on the next frame.
- R9: A frame strobe with no descriptor recorded is ignored.
- R10: A descriptor event in the same cycle as the frame strobe counts as that frame's last descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor consumed by the current frame |
| desc_addr | input | AW | Address of the consumed descriptor |
| frame_end | input | 1 | Frame fully received |
| frame_len | input | 11 | Received byte count |
| frame_err | input | 8 | Error code |
| wr_req | output | 1 | Status write request |
| wr_addr | output | AW | Descriptor address to write |
| wr_data | output | 32 | Status word |
| wr_gnt | input | 1 | Write accepted this cycle |
| done | output | 1 | Writeback of the frame finished |

## Verification
The assertions check on every cycle that a stalled request holds its address and data, that every requested word has the ownership bit clear and the complete bit set, that done is a single pulse directly after the last grant, and that recorded descriptor addresses do not move while events are refused. Only the bench scenarios can show the sequence of writes for each frame shape: how many writes there are, their address order, that the two copies are identical, and that middle descriptors stay unchanged in the memory model. The same holds for the refusal of stray strobes and of events during writeback, judged by the addresses the following frame writes.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned LEN_W  = 11;
    localparam int unsigned ERR_W  = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_COLLECT,
        S_WR_FIRST,
        S_WR_LAST,
        S_DONE
    } wb_state_t;

    function automatic logic [WORD_W-1:0] pack_status(
        input logic [LEN_W-1:0] len,
        input logic [ERR_W-1:0] err
    );
        logic [WORD_W-1:0] w;
        w        = '0;
        w[31]    = 1'b0;     // ownership back to software
        w[30]    = 1'b1;     // frame complete
        w[26:16] = len;
        w[9]     = 1'b1;     // first-descriptor flag
        w[8]     = 1'b1;     // last-descriptor flag
        w[7:0]   = err;
        return w;
    endfunction
endpackage

// File: rtl/rxwb_track.sv
module rxwb_track #(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          fresh,
    input  logic          desc_valid,
    input  logic [AW-1:0] desc_addr,
    output logic [AW-1:0] first_addr,
    output logic [AW-1:0] last_addr,
    output logic          multi
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_addr <= '0;
            last_addr  <= '0;
            multi      <= 1'b0;
        end else if (accept && desc_valid) begin
            if (fresh) begin
                first_addr <= desc_addr;
                last_addr  <= desc_addr;
                multi      <= 1'b0;
            end else begin
                last_addr  <= desc_addr;
                multi      <= 1'b1;
            end
        end
    end

    // R8: refused events leave the recorded addresses alone
    assert_hold_when_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(first_addr) && $stable(last_addr));
endmodule

// File: rtl/rxwb_fsm.sv
module rxwb_fsm
    import rxwb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               desc_valid,
    input  logic               frame_end,
    input  logic [LEN_W-1:0]   frame_len,
    input  logic [ERR_W-1:0]   frame_err,
    input  logic               multi,
    input  logic               wr_gnt,
    output logic               wr_req,
    output logic               sel_last,
    output logic               done,
    output logic               accept,
    output logic               fresh,
    output logic [WORD_W-1:0]  status
);
    wb_state_t state, state_nxt;
    logic      latch_status;

    always_comb begin
        state_nxt    = state;
        latch_status = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (desc_valid) begin
                    if (frame_end) begin
                        state_nxt    = S_WR_LAST;
                        latch_status = 1'b1;
                    end else begin
                        state_nxt = S_COLLECT;
                    end
                end
            end
            S_COLLECT: begin
                if (frame_end) begin
                    latch_status = 1'b1;
                    state_nxt    = (multi || desc_valid) ? S_WR_FIRST : S_WR_LAST;
                end
            end
            S_WR_FIRST: if (wr_gnt) state_nxt = S_WR_LAST;
            S_WR_LAST:  if (wr_gnt) state_nxt = S_DONE;
            S_DONE:     state_nxt = S_IDLE;
            default:    state_nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            status <= '0;
        end else begin
            state <= state_nxt;
            if (latch_status) status <= pack_status(frame_len, frame_err);
        end
    end

    always_comb begin
        wr_req   = (state == S_WR_FIRST) || (state == S_WR_LAST);
        sel_last = (state == S_WR_LAST);
        done     = (state == S_DONE);
        accept   = (state == S_IDLE) || (state == S_COLLECT);
        fresh    = (state == S_IDLE);
    end

    // R7: done only directly after the final grant
    assert_done_after_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(sel_last && wr_gnt));
    // R7: done lasts one cycle
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/rx_status_wb.sv
module rx_status_wb
    import rxwb_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_valid,
    input  logic [AW-1:0]     desc_addr,
    input  logic              frame_end,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic [ERR_W-1:0]  frame_err,
    output logic              wr_req,
    output logic [AW-1:0]     wr_addr,
    output logic [WORD_W-1:0] wr_data,
    input  logic              wr_gnt,
    output logic              done
);
    logic          accept, fresh, multi, sel_last;
    logic [AW-1:0] first_addr, last_addr;

    rxwb_track #(.AW(AW)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .fresh      (fresh),
        .desc_valid (desc_valid),
        .desc_addr  (desc_addr),
        .first_addr (first_addr),
        .last_addr  (last_addr),
        .multi      (multi)
    );

    rxwb_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .desc_valid (desc_valid),
        .frame_end  (frame_end),
        .frame_len  (frame_len),
        .frame_err  (frame_err),
        .multi      (multi),
        .wr_gnt     (wr_gnt),
        .wr_req     (wr_req),
        .sel_last   (sel_last),
        .done       (done),
        .accept     (accept),
        .fresh      (fresh),
        .status     (wr_data)
    );

    assign wr_addr = sel_last ? last_addr : first_addr;

    // R6: a waiting request keeps its address and data
    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_gnt) |=> wr_req && $stable(wr_addr) && $stable(wr_data));
    // R4: every requested word hands the descriptor back and marks completion
    assert_word_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (!wr_data[31] && wr_data[30] && wr_data[9] && wr_data[8]));
endmodule

// File: tb/tb_rx_status_wb.sv
module tb_rx_status_wb;
    localparam int unsigned AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          desc_valid = 1'b0;
    logic [AW-1:0] desc_addr = '0;
    logic          frame_end = 1'b0;
    logic [10:0]   frame_len = '0;
    logic [7:0]    frame_err = '0;
    logic          wr_req;
    logic [AW-1:0] wr_addr;
    logic [31:0]   wr_data;
    logic          wr_gnt = 1'b0;
    logic          done;

    int checks = 0;
    int fails  = 0;

    logic [31:0] mem [0:63];
    logic [AW-1:0] got_addr [0:3];
    logic [31:0]   got_data [0:3];
    int nwr;
    bit done_ok;

    always #2.5 clk = ~clk;

    rx_status_wb #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_addr(desc_addr),
        .frame_end(frame_end), .frame_len(frame_len), .frame_err(frame_err),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_gnt(wr_gnt), .done(done)
    );

    // fields: ndesc[39:36] same[35:32] gdelay[31:28] base[27:20] len[19:8] err[7:0]
    localparam logic [39:0] VEC [0:5] = '{
        {4'd1, 4'd0, 4'd0, 8'h00, 12'd64,   8'h00},
        {4'd2, 4'd0, 4'd0, 8'h20, 12'd1500, 8'h11},
        {4'd4, 4'd0, 4'd2, 8'h40, 12'd2047, 8'hA5},
        {4'd3, 4'd1, 4'd1, 8'h90, 12'd700,  8'h3C},
        {4'd1, 4'd1, 4'd3, 8'hC0, 12'd0,    8'hFF},
        {4'd2, 4'd1, 4'd0, 8'hD0, 12'd1024, 8'h80}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input logic [10:0] len, input logic [7:0] err);
        return {1'b0, 1'b1, 3'b000, len, 6'b000000, 1'b1, 1'b1, err};
    endfunction

    // serve grants until done, recording writes into the memory model
    task automatic serve(input int gdelay);
        int st = 0;
        int last_g = -10;
        nwr = 0;
        done_ok = 0;
        for (int cyc = 0; cyc < 60 && !done_ok; cyc++) begin
            @(negedge clk);
            wr_gnt = 1'b0;
            if (done) begin
                done_ok = 1;
                check(last_g == cyc - 1, "R7", "done not right after final grant",
                      32'(cyc - last_g), 32'd1);
            end else if (wr_req) begin
                if (st < gdelay) st++;
                else begin
                    wr_gnt = 1'b1;
                    if (nwr < 4) begin
                        got_addr[nwr] = wr_addr;
                        got_data[nwr] = wr_data;
                    end
                    mem[wr_addr[7:2]] = wr_data;
                    nwr++;
                    st = 0;
                    last_g = cyc;
                end
            end
        end
        @(negedge clk);
        check(!done, "R7", "done longer than one cycle", {31'b0, done}, 32'd0);
    endtask

    task automatic pulse_desc(input logic [AW-1:0] a, input bit with_end);
        @(negedge clk);
        desc_valid = 1'b1;
        desc_addr  = a;
        frame_end  = with_end;
        @(negedge clk);
        desc_valid = 1'b0;
        frame_end  = 1'b0;
    endtask

    task automatic end_frame(input logic [10:0] len, input logic [7:0] err);
        frame_len = len;
        frame_err = err;
        @(negedge clk);
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
    endtask

    task automatic init_mem();
        for (int i = 0; i < 64; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL R7 watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        init_mem();
        repeat (3) @(negedge clk);
        check(!wr_req && !done, "R1", "outputs during reset", {30'b0, wr_req, done}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!wr_req && !done, "R1", "outputs after reset", {30'b0, wr_req, done}, 32'd0);

        // table-driven frames: R2 R3 R4 R5 R7 R10
        for (int v = 0; v < 6; v++) begin
            int n = int'(VEC[v][39:36]);
            bit same = VEC[v][32];
            int gd = int'(VEC[v][31:28]);
            logic [7:0] base = VEC[v][27:20];
            logic [10:0] len = VEC[v][18:8];
            logic [7:0] err = VEC[v][7:0];
            logic [31:0] ew = exp_word(len, err);
            logic [AW-1:0] fa = AW'(base);
            logic [AW-1:0] la = AW'(base) + AW'((n - 1) * 16);
            init_mem();
            frame_len = len;
            frame_err = err;
            for (int d = 0; d < n; d++) begin
                pulse_desc(AW'(base) + AW'(d * 16), same && (d == n - 1));
                if (d < n - 1 || !same)
                    check(!wr_req, "R1", "write before frame end", {31'b0, wr_req}, 32'd0);
            end
            if (!same) end_frame(len, err);
            serve(gd);
            check(done_ok, "R7", "done seen", {31'b0, done_ok}, 32'd1);
            if (n == 1) begin
                check(nwr == 1, "R3", "single-descriptor write count", 32'(nwr), 32'd1);
                check(got_addr[0] == fa, "R3", "single write address", got_addr[0], fa);
                check(got_data[0] == ew, "R4", "status word", got_data[0], ew);
            end else begin
                check(nwr == 2, "R2", "multi-descriptor write count", 32'(nwr), 32'd2);
                check(got_addr[0] == fa, "R2", "first write address", got_addr[0], fa);
                check(got_addr[1] == la, same ? "R10" : "R2", "second write address", got_addr[1], la);
                check(got_data[0] == ew, "R4", "status word", got_data[0], ew);
                check(got_data[1] == got_data[0], "R2", "copies differ", got_data[1], got_data[0]);
                for (int d = 1; d < n - 1; d++) begin
                    int idx = (int'(base) + d * 16) / 4;
                    check(mem[idx] == (32'hDEAD_0000 | 32'(idx)), "R5", "middle descriptor written",
                          mem[idx], 32'hDEAD_0000 | 32'(idx));
                end
            end
        end

        // R9: frame strobe with nothing recorded
        end_frame(11'd99, 8'h01);
        repeat (4) begin
            @(negedge clk);
            check(!wr_req && !done, "R9", "stray frame strobe acted", {30'b0, wr_req, done}, 32'd0);
        end

        // R8: events during writeback are refused
        pulse_desc(32'h0000_0100, 1'b0);
        pulse_desc(32'h0000_0110, 1'b0);
        end_frame(11'd300, 8'h07);
        pulse_desc(32'h0000_0900, 1'b0);
        pulse_desc(32'h0000_0910, 1'b1);
        serve(0);
        check(nwr == 2, "R8", "write count with stray events", 32'(nwr), 32'd2);
        check(got_addr[0] == 32'h100, "R8", "first address kept", got_addr[0], 32'h100);
        check(got_addr[1] == 32'h110, "R8", "last address kept", got_addr[1], 32'h110);
        check(got_data[0] == exp_word(11'd300, 8'h07), "R8", "status kept",
              got_data[0], exp_word(11'd300, 8'h07));
        // next frame starts clean
        pulse_desc(32'h0000_0040, 1'b0);
        end_frame(11'd12, 8'h00);
        serve(1);
        check(nwr == 1, "R8", "next frame write count", 32'(nwr), 32'd1);
        check(got_addr[0] == 32'h40, "R8", "next frame address", got_addr[0], 32'h40);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule